// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block sits beside the instruction sequencer of a small 8-bit CPU. It keeps the interrupt master enable flag, decides at each instruction boundary whether an interrupt is taken, and runs the low-power halt state. The sequencer marks each completed instruction with a one-cycle strobe and flags whether that instruction was disable-interrupts, enable-interrupts, return-from-interrupt or halt. Two 5-bit registers come from the interrupt sources: the enable mask and the request flags. An interrupt is pending when their bitwise AND is nonzero.

When the controller takes an interrupt, it raises a one-cycle service request with a vector address and a one-hot mask. The interrupt sources use the mask to clear the serviced flag bit. The halted output stalls fetch. A one-cycle hold pulse tells the program counter to skip one increment, so that the byte after a halt is fetched twice. The enable instruction takes effect one instruction late. The halt exit path depends on both the enable flag and the pending state.

All outputs are registered. A decision taken at the clock edge that samples a boundary strobe (or, while halted, a pending interrupt) appears on the outputs right after that edge.

Top module: `irq_halt_ctrl`

## Requirements
- R1: A boundary flagged as disable-interrupts clears the enable flag at that boundary. It also cancels an enable that is still waiting to take effect, so the enable flag stays 0 after the next instruction.
- R2: A boundary flagged as enable-interrupts leaves the enable flag unchanged. The flag becomes 1 at the boundary of the next completed instruction, unless that instruction disables interrupts.
- R3: A boundary flagged as return-from-interrupt sets the enable flag at that same boundary, with no delay.
- R4: An interrupt is pending when (enable mask AND request flags) is nonzero. A service request is issued only at an instruction boundary, or while halted, and only when the enable flag (after this boundary's update) is 1. `svc_req` is high for exactly one cycle.
- R5: When several interrupts are pending, bit 0 has the highest priority. The vector is 0x40 + 8 × bit number, so bit 0 gives 0x40 and bit 4 gives 0x60; this keeps clear of the restart vectors 0x00 to 0x38. `svc_clr` has exactly the serviced bit set. `svc_vec` and `svc_clr` are 0 when no request is issued.
- R6: Taking an interrupt clears the enable flag.
- R7: A halt with the enable flag 0 and nothing pending raises `halted`. `halted` stays high while nothing is pending. It drops on the first cycle an interrupt is pending, and no service request is issued.
- R8: A halt with the enable flag 1 and nothing pending raises `halted`. When an interrupt becomes pending, `halted` drops and a service request is issued in the same cycle. If an interrupt is already pending at the halt boundary, the controller services it and does not halt.
- R9: A halt with the enable flag 0 and an interrupt already pending does not halt. It instead pulses `pc_hold` high for exactly one cycle.
- R10: Boundary strobes and their instruction flags are ignored while halted. They change neither the enable flag nor any delayed enable.
- R11: During reset, `ime`, `svc_req`, `svc_vec`, `svc_clr`, `halted` and `pc_hold` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Instruction-boundary strobe |
| op_di | input | 1 | Completed instruction disables interrupts |
| op_ei | input | 1 | Completed instruction enables interrupts (delayed) |
| op_reti | input | 1 | Completed instruction returns from an interrupt handler |
| op_halt | input | 1 | Completed instruction is a halt |
| irq_en | input | 5 | Interrupt enable mask |
| irq_flag | input | 5 | Interrupt request flags |
| ime | output | 1 | Master interrupt enable state |
| svc_req | output | 1 | One-cycle interrupt service request |
| svc_vec | output | 8 | Handler address for the serviced interrupt |
| svc_clr | output | 5 | One-hot mask of the flag bit to clear |
| halted | output | 1 | Halt state; stalls fetch |
| pc_hold | output | 1 | One-cycle suppression of the program counter increment |

## Verification
The hardest situation to reach is an enable instruction whose delayed effect is pending while other events race against it. One case is an enable that is followed directly by a halt while an interrupt is already pending. The other case is an enable that is issued while the controller is halted, where it must be ignored. The stimulus builds both cases from explicit instruction sequences. It issues an enable and, in the next boundary, a halt with a flag raised. After waking from a halt, it issues one plain instruction, which exposes any enable that should have been ignored. A reference model in the bench predicts every registered output for every cycle.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
   // core execution state seen by the halt logic
   typedef enum logic {
      CORE_RUN  = 1'b0,
      CORE_HALT = 1'b1
   } core_state_e;

   // restart vectors occupy 8 slots of 8 bytes starting at 0
   localparam int RESTART_SLOTS = 8;
   localparam int RESTART_STEP  = 8;
   localparam int RESTART_SPAN  = RESTART_SLOTS * RESTART_STEP;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N        = 5,
   parameter int VW       = 8,
   parameter int VEC_BASE = 64,
   parameter int VEC_STEP = 8
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [N-1:0]  grant,
   output logic [VW-1:0] vec
);
   localparam int VEC_TOP = VEC_BASE + VEC_STEP * (N - 1);

   if (N < 1) begin : g_bad_n
      $error("irq_prio_enc: N must be at least 1");
   end
   if (VEC_TOP >= (1 << VW)) begin : g_bad_vw
      $error("irq_prio_enc: vectors do not fit in VW bits");
   end

   // below[i] is set when some lower-numbered request is active
   logic [N:0] below;
   assign below[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]   = req[i] & ~below[i];
      assign below[i+1] = below[i] | req[i];
   end

   assign any = below[N];

   always_comb begin
      vec = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) vec = VW'(VEC_BASE + VEC_STEP * i);
      end
   end
endmodule

// File: rtl/irq_ime_ctrl.sv
module irq_ime_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic op_di,
   input  logic op_ei,
   input  logic op_reti,
   input  logic dispatch,
   output logic ime_now,
   output logic ime_q,
   output logic armed
);
   // enable value after this boundary's instruction, before any dispatch
   always_comb begin
      ime_now = ime_q;
      if (step) begin
         if (op_di)                ime_now = 1'b0;
         else if (op_reti || armed) ime_now = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ime_q <= 1'b0;
         armed <= 1'b0;
      end else begin
         ime_q <= dispatch ? 1'b0 : ime_now;
         if (step) armed <= op_ei & ~op_di;
      end
   end

   assert_di_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_di |=> !ime_q);
   assert_di_cancels_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_di |=> !armed);
   assert_ei_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_ei && !ime_q && !armed && !op_reti |=> !ime_q);
   assert_ei_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step && armed && !op_di && !dispatch |=> ime_q);
   assert_reti_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_reti && !op_di && !dispatch |=> ime_q);
   assert_take_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch |=> !ime_q);
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !dispatch |=> $stable(ime_q) && $stable(armed));
endmodule

// File: rtl/irq_halt_fsm.sv
module irq_halt_fsm
   import irq_halt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic instr_done,
   input  logic op_halt,
   input  logic ime_now,
   input  logic pending,
   output logic step,
   output logic dispatch,
   output logic halted,
   output logic pc_hold
);
   core_state_e state_q, state_d;
   logic        hold_d;

   assign halted   = (state_q == CORE_HALT);
   assign step     = instr_done & ~halted;
   assign dispatch = pending & ime_now & (step | halted);

   always_comb begin
      state_d = state_q;
      hold_d  = 1'b0;
      case (state_q)
         CORE_RUN: begin
            if (step && op_halt && !dispatch) begin
               if (!pending) state_d = CORE_HALT;
               else          hold_d  = 1'b1;
            end
         end
         CORE_HALT: begin
            if (pending) state_d = CORE_RUN;
         end
         default: state_d = CORE_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CORE_RUN;
         pc_hold <= 1'b0;
      end else begin
         state_q <= state_d;
         pc_hold <= hold_d;
      end
   end

   assert_stay_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted && !pending |=> halted);
   assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted && pending |=> !halted);
   assert_hold_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |=> !pc_hold);
   assert_no_sleep_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_halt && pending |=> !halted);
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl #(
   parameter int NUM_SRC  = 5,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 64,
   parameter int VEC_STEP = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_done,
   input  logic               op_di,
   input  logic               op_ei,
   input  logic               op_reti,
   input  logic               op_halt,
   input  logic [NUM_SRC-1:0] irq_en,
   input  logic [NUM_SRC-1:0] irq_flag,
   output logic               ime,
   output logic               svc_req,
   output logic [VEC_W-1:0]   svc_vec,
   output logic [NUM_SRC-1:0] svc_clr,
   output logic               halted,
   output logic               pc_hold
);
   import irq_halt_pkg::*;

   if (VEC_BASE < RESTART_SPAN) begin : g_bad_base
      $error("irq_halt_ctrl: vector base overlaps the restart vectors");
   end
   if (VEC_STEP < 1) begin : g_bad_step
      $error("irq_halt_ctrl: vector step must be positive");
   end

   logic [NUM_SRC-1:0] pend_vec, grant;
   logic [VEC_W-1:0]   vec;
   logic               pending, step, dispatch, ime_now, armed;

   assign pend_vec = irq_en & irq_flag;

   irq_prio_enc #(
      .N(NUM_SRC), .VW(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
   ) u_prio (
      .req(pend_vec), .any(pending), .grant(grant), .vec(vec)
   );

   irq_ime_ctrl u_ime (
      .clk(clk), .rst_n(rst_n), .step(step),
      .op_di(op_di), .op_ei(op_ei), .op_reti(op_reti),
      .dispatch(dispatch), .ime_now(ime_now), .ime_q(ime), .armed(armed)
   );

   irq_halt_fsm u_halt (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .op_halt(op_halt),
      .ime_now(ime_now), .pending(pending), .step(step),
      .dispatch(dispatch), .halted(halted), .pc_hold(pc_hold)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         svc_req <= 1'b0;
         svc_vec <= '0;
         svc_clr <= '0;
      end else begin
         svc_req <= dispatch;
         svc_vec <= dispatch ? vec   : '0;
         svc_clr <= dispatch ? grant : '0;
      end
   end

   assert_one_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> $countones(svc_clr) == 1);
   assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> ((svc_clr - NUM_SRC'(1)) & $past(pend_vec)) == '0);
   assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |=> !svc_req);
   assert_req_drops_ime_R6: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> !ime);
endmodule

// File: tb/tb_irq_halt_ctrl.sv
module tb_irq_halt_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       instr_done, op_di, op_ei, op_reti, op_halt;
   logic [4:0] irq_en, irq_flag;
   logic       ime, svc_req, halted, pc_hold;
   logic [7:0] svc_vec;
   logic [4:0] svc_clr;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   irq_halt_ctrl dut (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
      .op_di(op_di), .op_ei(op_ei), .op_reti(op_reti), .op_halt(op_halt),
      .irq_en(irq_en), .irq_flag(irq_flag),
      .ime(ime), .svc_req(svc_req), .svc_vec(svc_vec), .svc_clr(svc_clr),
      .halted(halted), .pc_hold(pc_hold)
   );

   typedef struct {
      logic       ime;
      logic       req;
      logic [7:0] vec;
      logic [4:0] clr;
      logic       halted;
      logic       hold;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   // reference model state
   logic m_ime = 1'b0, m_armed = 1'b0, m_halted = 1'b0;

   task automatic cyc(input logic d, input logic di, input logic ei,
                      input logic reti, input logic hlt,
                      input logic [4:0] en, input logic [4:0] fl,
                      input string tag);
      exp_t e;
      logic [4:0] pend;
      logic step, ime_n, disp;
      @(negedge clk);
      instr_done = d; op_di = di; op_ei = ei; op_reti = reti; op_halt = hlt;
      irq_en = en; irq_flag = fl;
      pend  = en & fl;
      step  = d && !m_halted;
      ime_n = m_ime;
      if (step) begin
         if (di) ime_n = 1'b0;
         else if (reti || m_armed) ime_n = 1'b1;
      end
      disp = (pend != 0) && ime_n && (step || m_halted);
      e.req = disp; e.vec = 8'h00; e.clr = 5'b0;
      if (disp) begin
         for (int i = 4; i >= 0; i--) begin
            if (pend[i]) begin
               e.vec = 8'(8'h40 + 8 * i);
               e.clr = 5'b00001 << i;
            end
         end
      end
      e.hold = step && hlt && (pend != 0) && !ime_n && !disp;
      if (m_halted)                        m_halted = (pend == 0);
      else if (step && hlt && pend == 0)   m_halted = 1'b1;
      if (step) m_armed = ei && !di;
      m_ime    = disp ? 1'b0 : ime_n;
      e.ime    = m_ime;
      e.halted = m_halted;
      e.tag    = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares one expected item after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (ime !== e.ime || svc_req !== e.req || svc_vec !== e.vec ||
                svc_clr !== e.clr || halted !== e.halted || pc_hold !== e.hold) begin
               bad++;
               $display("FAIL %s: got ime=%0b req=%0b vec=%02h clr=%05b halted=%0b hold=%0b expected ime=%0b req=%0b vec=%02h clr=%05b halted=%0b hold=%0b",
                        e.tag, ime, svc_req, svc_vec, svc_clr, halted, pc_hold,
                        e.ime, e.req, e.vec, e.clr, e.halted, e.hold);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      instr_done = 0; op_di = 0; op_ei = 0; op_reti = 0; op_halt = 0;
      irq_en = '0; irq_flag = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      total++;
      if (ime !== 0 || svc_req !== 0 || svc_vec !== 0 || svc_clr !== 0 ||
          halted !== 0 || pc_hold !== 0) begin
         bad++;
         $display("FAIL R11: got ime=%0b req=%0b vec=%02h clr=%05b halted=%0b hold=%0b expected all zero",
                  ime, svc_req, svc_vec, svc_clr, halted, pc_hold);
      end
      rst_n = 1'b1;

      cyc(0, 0, 0, 0, 0, 5'h00, 5'h00, "R11");
      // R2: enable lands one instruction late
      cyc(1, 0, 1, 0, 0, 5'h00, 5'h00, "R2");
      cyc(1, 0, 0, 0, 0, 5'h00, 5'h00, "R2");
      // R1: disable is immediate and cancels a waiting enable
      cyc(1, 1, 0, 0, 0, 5'h00, 5'h00, "R1");
      cyc(1, 0, 1, 0, 0, 5'h00, 5'h00, "R1");
      cyc(1, 1, 0, 0, 0, 5'h00, 5'h00, "R1");
      cyc(1, 0, 0, 0, 0, 5'h00, 5'h00, "R1");
      // R3: return-from-interrupt enables at once
      cyc(1, 0, 0, 1, 0, 5'h00, 5'h00, "R3");
      // R4: no request without pending or without a boundary
      cyc(1, 0, 0, 0, 0, 5'h1f, 5'h00, "R4");
      cyc(0, 0, 0, 0, 0, 5'h1f, 5'h16, "R4");
      // R5/R6: lowest pending bit wins, enable cleared
      cyc(1, 0, 0, 0, 0, 5'h1f, 5'h16, "R5");
      cyc(1, 0, 0, 0, 0, 5'h1f, 5'h16, "R6");
      // R4: masked flags are not pending
      cyc(1, 0, 0, 1, 0, 5'h06, 5'h18, "R4");
      cyc(1, 0, 0, 0, 0, 5'h1f, 5'h10, "R5");
      // R7 and R10: halt with enable 0, nothing pending
      cyc(1, 0, 0, 0, 1, 5'h1f, 5'h00, "R7");
      cyc(1, 0, 0, 1, 0, 5'h1f, 5'h00, "R10");
      cyc(1, 0, 1, 0, 0, 5'h1f, 5'h00, "R10");
      cyc(0, 0, 0, 0, 0, 5'h1f, 5'h00, "R10");
      cyc(0, 0, 0, 0, 0, 5'h1f, 5'h04, "R7");
      cyc(1, 0, 0, 0, 0, 5'h1f, 5'h00, "R10");
      cyc(1, 0, 0, 0, 0, 5'h1f, 5'h00, "R10");
      // R8: halt with enable 1, wake into service
      cyc(1, 0, 0, 1, 0, 5'h1f, 5'h00, "R8");
      cyc(1, 0, 0, 0, 1, 5'h1f, 5'h00, "R8");
      cyc(0, 0, 0, 0, 0, 5'h1f, 5'h00, "R8");
      cyc(0, 0, 0, 0, 0, 5'h1f, 5'h08, "R8");
      cyc(0, 0, 0, 0, 0, 5'h1f, 5'h00, "R8");
      // R9: halt with enable 0 and pending gives a single hold pulse
      cyc(1, 0, 0, 0, 1, 5'h1f, 5'h01, "R9");
      cyc(1, 0, 0, 0, 0, 5'h1f, 5'h00, "R9");
      // R8: enable then halt with a pending interrupt is serviced
      cyc(1, 0, 1, 0, 0, 5'h1f, 5'h00, "R2");
      cyc(1, 0, 0, 0, 1, 5'h1f, 5'h01, "R8");
      cyc(1, 0, 0, 1, 0, 5'h1f, 5'h00, "R3");
      cyc(1, 0, 0, 0, 1, 5'h1f, 5'h0c, "R8");
      cyc(0, 0, 0, 0, 0, 5'h00, 5'h00, "R8");
      @(negedge clk);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule